// File: doc/BRIEF.md
# Frame-Power Talker Detector

This block decides, for one audio channel, whether a participant is talking. It squares each signed linear PCM sample as it arrives on a sample strobe and sums the squares over a fixed 20 ms frame. At the end of the frame it divides the sum by the frame length to give the frame's mean power, which it presents as a level word.

The level word is compared with an unsigned threshold to give a per-frame voice flag. A talker flag follows the voice flag with two separate delays, each counted in 10 ms units. The onset guard sets how long voice must persist before the talker flag rises. The release guard sets how long silence must persist before the flag falls.

The channel runs at either 8 kHz or 16 kHz. Frame boundaries are free-running and are not tied to any external reference. The threshold is given in the same power scale as the level word.

Top module: `ftd_talker_detect`

## Requirements
- R1: After reset, level_o is 0, voice_o is 0 and talker_o is 0.
- R2: With wide_i = 0 a frame is FRAME_NB strobed samples (160 by default, 8 kHz). With wide_i = 1 a frame is FRAME_WB strobed samples (320, 16 kHz).
- R3: After each frame, level_o becomes floor(sum of the squares of the frame's samples / frame length). It is updated within ACC_W+3 cycles of the frame's last strobe and otherwise holds its value. Strobes must be spaced so that this completes before the next frame ends.
- R4: At each level update, voice_o becomes 1 when the new level is greater than or equal to thr_i, and 0 otherwise.
- R5: A 10 ms tick occurs on the strobe that ends each half frame. talker_o rises on the tick where voice_o has differed from talker_o for fwd_i consecutive ticks. A code of 0 behaves as 1.
- R6: talker_o falls on the tick where voice_o has been 0 while talker_o was 1 for bwd_i consecutive ticks. A code of 0 behaves as 1.
- R7: When voice_o returns to the value of talker_o before the guard count is reached, the count restarts from zero and talker_o does not change.
- R8: A change of wide_i discards the partial frame and its partial sum. The next strobe starts a new frame of the new length. A strobe in the same cycle as the change is dropped.
- R9: sample_i is ignored whenever strobe_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Sample valid, one cycle per sample |
| sample_i | input | SAMPLE_W | Signed linear PCM sample |
| wide_i | input | 1 | Rate mode: 0 = 8 kHz, 1 = 16 kHz |
| thr_i | input | 2*SAMPLE_W | Voice threshold in level units |
| fwd_i | input | FWD_W | Onset guard, 10 ms units |
| bwd_i | input | BWD_W | Release guard, 10 ms units |
| level_o | output | 2*SAMPLE_W | Mean power of the last complete frame |
| voice_o | output | 1 | Voice decision of the last frame |
| talker_o | output | 1 | Guarded talker decision |

## Verification
The bench builds the block with FRAME_NB = 8 and FRAME_WB = 16, so that a tick falls every 4 or 8 strobes and the full 63-tick onset and 31-tick release guards can be run out in a few tens of thousands of cycles. SAMPLE_W stays at 16, which keeps the full-scale sample -32768 and the 2^30 level it produces in range. The accumulator shrinks to 36 bits, and the divider then finishes well inside the 50-cycle strobe spacing the bench uses.

// File: rtl/ftd_pkg.sv
package ftd_pkg;
  typedef enum logic {
    RATE_NARROW = 1'b0,
    RATE_WIDE   = 1'b1
  } rate_e;
endpackage

// File: rtl/ftd_frame_acc.sv
module ftd_frame_acc
  import ftd_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int FRAME_NB = 160,
  parameter int FRAME_WB = 320,
  parameter int LVL_W    = 2 * SAMPLE_W,
  parameter int ACC_W    = LVL_W + $clog2(FRAME_WB),
  parameter int IDX_W    = $clog2(FRAME_WB + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       strobe_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic                       wide_i,
  output logic                       tick_o,
  output logic                       frame_end_o,
  output logic [ACC_W-1:0]           frame_sum_o,
  output logic [IDX_W-1:0]           frame_len_o,
  output logic [IDX_W-1:0]           idx_o
);
  rate_e                        mode_q;
  logic [IDX_W-1:0]             idx_q, len, half;
  logic [ACC_W-1:0]             acc_q, acc_n;
  logic signed [LVL_W-1:0]      prod;
  logic [LVL_W-1:0]             sq;
  logic                         mode_chg, last;

  assign mode_chg = (rate_e'(wide_i) != mode_q);
  assign len      = (mode_q == RATE_WIDE) ? IDX_W'(FRAME_WB) : IDX_W'(FRAME_NB);
  assign half     = len >> 1;
  assign last     = (idx_q == len - IDX_W'(1));
  assign prod     = sample_i * sample_i;
  assign sq       = $unsigned(prod);
  assign acc_n    = acc_q + ACC_W'(sq);
  assign tick_o   = strobe_i && !mode_chg && (last || idx_q == half - IDX_W'(1));
  assign idx_o    = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= RATE_NARROW;
      idx_q       <= '0;
      acc_q       <= '0;
      frame_end_o <= 1'b0;
      frame_sum_o <= '0;
      frame_len_o <= IDX_W'(FRAME_NB);
    end else begin
      frame_end_o <= 1'b0;
      if (mode_chg) begin
        // restart framing at the new rate
        mode_q <= rate_e'(wide_i);
        idx_q  <= '0;
        acc_q  <= '0;
      end else if (strobe_i) begin
        if (last) begin
          frame_sum_o <= acc_n;
          frame_len_o <= len;
          frame_end_o <= 1'b1;
          acc_q       <= '0;
          idx_q       <= '0;
        end else begin
          acc_q <= acc_n;
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ftd_mean_div.sv
module ftd_mean_div #(
  parameter int ACC_W = 41,
  parameter int DIV_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ACC_W-1:0] dividend_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             busy_o,
  output logic             vld_o,
  output logic [ACC_W-1:0] quo_o
);
  localparam int CNT_W = $clog2(ACC_W + 1);

  logic [ACC_W-1:0] dq_q, dq_n;
  logic [DIV_W-1:0] rem_q, rem_n, dvs_q;
  logic [DIV_W:0]   trial, diff;
  logic [CNT_W-1:0] cnt_q;
  logic             ge;

  // restoring division, one quotient bit per cycle
  assign trial = {rem_q, dq_q[ACC_W-1]};
  assign ge    = (trial >= {1'b0, dvs_q});
  assign diff  = trial - {1'b0, dvs_q};
  assign rem_n = ge ? diff[DIV_W-1:0] : trial[DIV_W-1:0];
  assign dq_n  = {dq_q[ACC_W-2:0], ge};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_q   <= '0;
      rem_q  <= '0;
      dvs_q  <= DIV_W'(1);
      cnt_q  <= '0;
      busy_o <= 1'b0;
      vld_o  <= 1'b0;
      quo_o  <= '0;
    end else begin
      vld_o <= 1'b0;
      if (start_i) begin
        dq_q   <= dividend_i;
        rem_q  <= '0;
        dvs_q  <= divisor_i;
        cnt_q  <= CNT_W'(ACC_W);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        dq_q  <= dq_n;
        rem_q <= rem_n;
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_o <= 1'b0;
          vld_o  <= 1'b1;
          quo_o  <= dq_n;
        end
      end
    end
  end
endmodule

// File: rtl/ftd_guard.sv
module ftd_guard #(
  parameter int FWD_W = 6,
  parameter int BWD_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             voice_i,
  input  logic [FWD_W-1:0] fwd_i,
  input  logic [BWD_W-1:0] bwd_i,
  output logic             talker_o
);
  localparam int CNT_W = (FWD_W > BWD_W) ? FWD_W : BWD_W;

  logic [CNT_W-1:0] cnt_q, lim, lim_eff;
  logic             pending, reached;

  assign lim     = talker_o ? CNT_W'(bwd_i) : CNT_W'(fwd_i);
  assign lim_eff = (lim == '0) ? CNT_W'(1) : lim;
  assign pending = (voice_i != talker_o);
  assign reached = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, lim_eff};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      talker_o <= 1'b0;
    end else if (!pending) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (reached) begin
        talker_o <= voice_i;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ftd_talker_detect.sv
module ftd_talker_detect #(
  parameter int SAMPLE_W = 16,
  parameter int FRAME_NB = 160,
  parameter int FRAME_WB = 320,
  parameter int FWD_W    = 6,
  parameter int BWD_W    = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       strobe_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic                       wide_i,
  input  logic [2*SAMPLE_W-1:0]      thr_i,
  input  logic [FWD_W-1:0]           fwd_i,
  input  logic [BWD_W-1:0]           bwd_i,
  output logic [2*SAMPLE_W-1:0]      level_o,
  output logic                       voice_o,
  output logic                       talker_o
);
  localparam int LVL_W = 2 * SAMPLE_W;
  localparam int IDX_W = $clog2(FRAME_WB + 1);
  localparam int ACC_W = LVL_W + $clog2(FRAME_WB);

  logic             tick, frame_end, div_busy, div_vld;
  logic [ACC_W-1:0] frame_sum, quo;
  logic [IDX_W-1:0] frame_len, idx;

  ftd_frame_acc #(
    .SAMPLE_W(SAMPLE_W), .FRAME_NB(FRAME_NB), .FRAME_WB(FRAME_WB),
    .LVL_W(LVL_W), .ACC_W(ACC_W), .IDX_W(IDX_W)
  ) i_acc (
    .clk_i, .rst_ni, .strobe_i, .sample_i, .wide_i,
    .tick_o(tick), .frame_end_o(frame_end), .frame_sum_o(frame_sum),
    .frame_len_o(frame_len), .idx_o(idx)
  );

  ftd_mean_div #(.ACC_W(ACC_W), .DIV_W(IDX_W)) i_div (
    .clk_i, .rst_ni, .start_i(frame_end), .dividend_i(frame_sum),
    .divisor_i(frame_len), .busy_o(div_busy), .vld_o(div_vld), .quo_o(quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o <= '0;
      voice_o <= 1'b0;
    end else if (div_vld) begin
      level_o <= quo[LVL_W-1:0];
      voice_o <= (quo >= ACC_W'(thr_i));
    end
  end

  ftd_guard #(.FWD_W(FWD_W), .BWD_W(BWD_W)) i_guard (
    .clk_i, .rst_ni, .tick_i(tick), .voice_i(voice_o),
    .fwd_i, .bwd_i, .talker_o
  );
endmodule

// File: rtl/ftd_checker.sv
module ftd_checker #(
  parameter int LVL_W    = 32,
  parameter int IDX_W    = 9,
  parameter int FRAME_WB = 320
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LVL_W-1:0] thr_i,
  input logic [LVL_W-1:0] level_o,
  input logic             voice_o,
  input logic             talker_o,
  input logic             tick,
  input logic             frame_end,
  input logic             div_busy,
  input logic             div_vld,
  input logic [IDX_W-1:0] idx
);
  // R2: sample index stays inside the longest frame
  p_idx_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx < IDX_W'(FRAME_WB));

  p_level_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(div_vld) |-> $stable(level_o));

  p_no_overrun_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end |-> !div_busy);

  p_voice_thr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_vld |=> (voice_o == (level_o >= $past(thr_i))));

  p_rise_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(talker_o) |-> ($past(tick) && $past(voice_o)));

  p_fall_on_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(talker_o) |-> ($past(tick) && !$past(voice_o)));
endmodule

bind ftd_talker_detect ftd_checker #(
  .LVL_W(LVL_W), .IDX_W(IDX_W), .FRAME_WB(FRAME_WB)
) i_ftd_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .thr_i(thr_i), .level_o(level_o),
  .voice_o(voice_o), .talker_o(talker_o), .tick(tick),
  .frame_end(frame_end), .div_busy(div_busy), .div_vld(div_vld), .idx(idx)
);

// File: tb/test_ftd_talker_detect.sv
module test_ftd_talker_detect;
  localparam int SW  = 16;
  localparam int NB  = 8;
  localparam int WB  = 16;
  localparam int GAP = 50;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 strobe_i = 1'b0;
  logic signed [SW-1:0] sample_i = '0;
  logic                 wide_i = 1'b0;
  logic [2*SW-1:0]      thr_i = '0;
  logic [5:0]           fwd_i = '0;
  logic [4:0]           bwd_i = '0;
  logic [2*SW-1:0]      level_o;
  logic                 voice_o, talker_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  int     m_idx = 0, m_cnt = 0;
  longint m_sum = 0, m_level = 0;
  bit     m_voice = 0, m_talk = 0, m_wide = 0;
  string  g_tag = "R3";

  always #4 clk = ~clk;

  ftd_talker_detect #(.SAMPLE_W(SW), .FRAME_NB(NB), .FRAME_WB(WB)) i_ftd_talker_detect (
    .clk_i(clk), .rst_ni, .strobe_i, .sample_i, .wide_i, .thr_i,
    .fwd_i, .bwd_i, .level_o, .voice_o, .talker_o
  );

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic int frame_len();
    return m_wide ? WB : NB;
  endfunction

  // advance the model by one strobed sample
  task automatic model_step(int s, longint thr, int fwd, int bwd);
    int len = frame_len();
    int lim;
    m_idx++;
    m_sum += longint'(s) * longint'(s);
    if (m_idx == len / 2 || m_idx == len) begin
      lim = m_talk ? bwd : fwd;
      if (lim == 0) lim = 1;
      if (m_voice != m_talk) begin
        m_cnt++;
        if (m_cnt >= lim) begin
          m_talk = m_voice;
          m_cnt  = 0;
        end
      end
    end
    if (m_idx == len) begin
      m_level = m_sum / len;
      m_voice = (m_level >= thr);
      if (m_voice == m_talk) m_cnt = 0;
      m_sum = 0;
      m_idx = 0;
    end
  endtask

  task automatic send(int s, longint thr, int fwd, int bwd);
    @(negedge clk);
    strobe_i = 1'b1;
    sample_i = SW'(s);
    thr_i    = 32'(thr);
    fwd_i    = 6'(fwd);
    bwd_i    = 5'(bwd);
    @(negedge clk);
    strobe_i = 1'b0;
    sample_i = SW'($urandom);  // R9: noise while strobe is low
    model_step(s, thr, fwd, bwd);
    repeat (GAP - 2) @(negedge clk);
    check({g_tag, " level"}, longint'(level_o), m_level);
    check("R4 voice", longint'(voice_o), longint'(m_voice));
    check("R5,R6,R7 talker", longint'(talker_o), longint'(m_talk));
  endtask

  task automatic send_frame(int lo, int hi, longint thr, int fwd, int bwd);
    for (int i = 0; i < frame_len(); i++)
      send(lo + int'($urandom_range(0, hi - lo)), thr, fwd, bwd);
  endtask

  task automatic set_mode(bit w);
    @(negedge clk);
    wide_i = w;
    if (w != m_wide) begin
      m_idx  = 0;
      m_sum  = 0;
      m_wide = w;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 level", longint'(level_o), 0);
    check("R1 voice", longint'(voice_o), 0);
    check("R1 talker", longint'(talker_o), 0);

    // R4 boundary: level equal to threshold counts as voice; R5 code 0
    g_tag = "R2";
    send_frame(100, 100, 10000, 0, 0);
    send_frame(100, 100, 10001, 0, 0);
    send_frame(-100, -100, 10000, 0, 0);
    // full-scale negative samples
    send_frame(-32768, -32768, 64'd1073741824, 1, 1);
    send_frame(-32768, -32768, 64'd1073741825, 1, 1);

    // R7: short bursts against a long onset guard
    g_tag = "R3";
    for (int k = 0; k < 4; k++) begin
      send_frame(15000, 20000, 1000000, 5, 3);
      send_frame(-300, 300, 1000000, 5, 3);
    end

    // random traffic, 8 kHz
    for (int k = 0; k < 40; k++) begin
      bit loud = $urandom_range(0, 1);
      int a    = loud ? 20000 : 300;
      send_frame(-a, a, 1000000, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
    end

    // maximum guard codes (R5, R6)
    for (int k = 0; k < 33; k++) send_frame(-20000, 20000, 1000000, 63, 31);
    for (int k = 0; k < 17; k++) send_frame(-200, 200, 1000000, 63, 31);

    // 16 kHz random traffic
    set_mode(1'b1);
    for (int k = 0; k < 12; k++) begin
      bit loud = $urandom_range(0, 1);
      int a    = loud ? 25000 : 500;
      send_frame(-a, a, 2000000, int'($urandom_range(0, 4)), int'($urandom_range(0, 4)));
    end

    // R8: switch rate mid-frame; partial sum must be dropped
    g_tag = "R8";
    for (int i = 0; i < 5; i++) send(30000, 2000000, 2, 2);
    set_mode(1'b0);
    send_frame(10, 10, 2000000, 2, 2);
    for (int i = 0; i < 3; i++) send(-30000, 2000000, 2, 2);
    set_mode(1'b1);
    send_frame(50, 60, 2000000, 2, 2);
    set_mode(1'b0);
    send_frame(-20000, 20000, 2000000, 2, 2);

    done = 1;
    finish_run();
  end
endmodule